// File: doc/BRIEF.md
# TDM Timeslot PRBS Pattern Checker

The block watches a time-division-multiplexed receive stream that carries up to 60 serial links, each with 512 byte-wide timeslots per 125 µs frame. The stream arrives already deserialised: one byte per cycle, tagged with its link and timeslot number, plus a pulse at the start of every frame. Software selects one link and one timeslot. Each time that slot goes by, the block captures its byte and checks it. The check is either against a fixed expected byte (static mode) or against a PRBS11 sequence with polynomial x^11 + x^9 + 1 (PRBS mode). In PRBS mode the checker aligns itself to the received bits without any seed.

Once the checker has locked, it counts checked frames and bit errors in two saturating counters. A small register port holds the link/slot select, the last captured byte, the control word and the counters. The central state machine has four states. IDLE means the checker is stopped or not yet fed. LOAD means it is filling the 11-bit history from received bits. VERIFY means it is counting consecutive bits that match the prediction. LOCKED means it is counting frames and errors.

The transitions are:
- start: IDLE to LOAD on the first captured byte in PRBS mode.
- filled: LOAD to VERIFY after 11 bits.
- slip: VERIFY to LOAD on a mispredicted bit.
- lock: VERIFY to LOCKED after 11 matching bits.
- loss: LOCKED to LOAD when a 4-frame window holds 8 or more errors.
- static: IDLE to LOCKED on the first captured byte in static mode.
- stop: any state to IDLE when the checker is not running or is restarted.

Top module: `tdm_slot_prbs_checker`

Register map (reg_addr):
- 0: select. Link in [15:10], timeslot in [8:0], bit 9 reads 0.
- 1: captured byte in [7:0].
- 2: control. Bit 0 is enable. Bit 1 is mode (1 = PRBS, 0 = static). Bit 2 is clear, write-one, reads 0. Expected static byte in [15:8].
- 3 and 4: frame count, low and high halves.
- 5 and 6: error count, low and high halves.
- 7: status. Bit 0 is locked, bit 1 is running.

## Requirements
- R1: The select register reads back link in [15:10], timeslot in [8:0] and 0 in bit 9. It becomes 0 after rst_n low and after a soft_rst pulse.
- R2: A byte with rx_valid whose rx_slot equals the selected slot, and whose rx_link equals the selected link, is stored and readable at address 1. A selected link of 60 to 63 matches link 0. Bytes on any other link or slot leave the stored byte unchanged.
- R3: In PRBS mode the bits of each byte are taken MSB first. The checker loads 11 received bits, then needs 11 consecutive bits that each equal the XOR of the bits received 9 and 11 positions earlier. It then enters LOCKED (status bit 0 = 1). No frame or error is counted before that.
- R4: A captured byte that arrives while in LOCKED adds 1 to the frame count. Each of its bits that differs from the prediction adds 1 to the error count. The prediction keeps running from predicted bits, so an error does not spread.
- R5: In static mode every captured byte while running is counted as a frame. Its number of bits differing from control[15:8] is added to the error count.
- R6: In PRBS mode the counted frames are grouped into windows of 4, starting at lock. A window holding 8 or more errors sends the checker to LOAD (status bit 0 = 0), and it must lock again before counting resumes.
- R7: Both counters saturate at their all-ones value.
- R8: Writing control with bit 2 = 1, or changing enable from 0 to 1, clears both counters. The clear wins over an increment in the same cycle.
- R9: After enable is written 0, captured bytes are still checked until the next frame_start. Then running (status bit 1) drops, the checker returns to IDLE and later bytes are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| frame_start | input | 1 | Pulse at each 125 µs frame boundary |
| rx_valid | input | 1 | A byte is present on the stream |
| rx_link | input | 6 | Link number of the present byte |
| rx_slot | input | 9 | Timeslot number of the present byte |
| rx_data | input | 8 | Received byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |

## Verification
Two actions can fall in the same cycle. One is a counter clear from the control register. The other is the counter increment from a byte that the state machine is judging in that cycle. The bench writes the clear bit in exactly the cycle after the byte is captured, which is the cycle in which the increment would land. It then expects both counters to read zero, because the clear has priority. A second case pairs the disable write with bytes that still arrive before the frame boundary, and checks which of them are counted.

// File: rtl/tdm_prbs_pkg.sv
package tdm_prbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_VERIFY = 2'd2,
        ST_LOCKED = 2'd3
    } chk_state_e;

    localparam logic [2:0] A_SEL    = 3'd0;
    localparam logic [2:0] A_RXD    = 3'd1;
    localparam logic [2:0] A_CTRL   = 3'd2;
    localparam logic [2:0] A_FRM_LO = 3'd3;
    localparam logic [2:0] A_FRM_HI = 3'd4;
    localparam logic [2:0] A_ERR_LO = 3'd5;
    localparam logic [2:0] A_ERR_HI = 3'd6;
    localparam logic [2:0] A_STAT   = 3'd7;
endpackage

// File: rtl/tdm_slot_tap.sv
module tdm_slot_tap #(
    parameter int NUM_LINKS = 60,
    parameter int LINK_W    = 6,
    parameter int SLOT_W    = 9,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [LINK_W-1:0] sel_link,
    input  logic [SLOT_W-1:0] sel_slot,
    input  logic              rx_valid,
    input  logic [LINK_W-1:0] rx_link,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] capt_data,
    output logic              capt_stb
);
    localparam logic [LINK_W-1:0] LINK_LIMIT = LINK_W'(NUM_LINKS);

    logic [LINK_W-1:0] eff_link;
    logic              hit;

    // Out-of-range link selections fold onto link 0.
    assign eff_link = (sel_link >= LINK_LIMIT) ? '0 : sel_link;
    assign hit      = rx_valid && (rx_link == eff_link) && (rx_slot == sel_slot);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            capt_data <= '0;
            capt_stb  <= 1'b0;
        end else if (soft_rst) begin
            capt_data <= '0;
            capt_stb  <= 1'b0;
        end else begin
            capt_stb <= hit;
            if (hit) capt_data <= rx_data;
        end
    end

    // R2: the held byte only moves when a slot match was taken
    p_capt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!capt_stb && !$past(soft_rst)) |-> $stable(capt_data));
endmodule

// File: rtl/prbs_lock_fsm.sv
module prbs_lock_fsm
    import tdm_prbs_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LFSR_W     = 11,
    parameter int TAP_A      = 9,
    parameter int LOCK_BITS  = 11,
    parameter int WIN_FRAMES = 4,
    parameter int LOL_ERR    = 8,
    localparam int EW        = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              run,
    input  logic              restart,
    input  logic              prbs_mode,
    input  logic [DATA_W-1:0] exp_byte,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    output logic              locked,
    output logic              frame_inc,
    output logic [EW-1:0]     err_inc
);
    localparam int BMAX = (LFSR_W > LOCK_BITS) ? LFSR_W : LOCK_BITS;
    localparam int BC_W = $clog2(BMAX + 1);
    localparam int WC_W = (WIN_FRAMES > 1) ? $clog2(WIN_FRAMES) : 1;
    localparam int WE_W = $clog2(WIN_FRAMES * DATA_W + 1);

    chk_state_e        st_q, st_n;
    logic [LFSR_W-1:0] hist_q, hist_n;
    logic [BC_W-1:0]   bcnt_q, bcnt_n;
    logic [WC_W-1:0]   wcnt_q, wcnt_n;
    logic [WE_W-1:0]   werr_q, werr_n;
    logic              counted;
    logic [EW-1:0]     errs;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            hist_q <= '0;
            bcnt_q <= '0;
            wcnt_q <= '0;
            werr_q <= '0;
        end else if (soft_rst) begin
            st_q   <= ST_IDLE;
            hist_q <= '0;
            bcnt_q <= '0;
            wcnt_q <= '0;
            werr_q <= '0;
        end else begin
            st_q   <= st_n;
            hist_q <= hist_n;
            bcnt_q <= bcnt_n;
            wcnt_q <= wcnt_n;
            werr_q <= werr_n;
        end
    end

    // Next-state process: one captured byte is walked bit by bit
    always_comb begin
        chk_state_e      s;
        logic            b, p;
        logic [WE_W-1:0] sum;
        st_n    = st_q;
        hist_n  = hist_q;
        bcnt_n  = bcnt_q;
        wcnt_n  = wcnt_q;
        werr_n  = werr_q;
        counted = 1'b0;
        errs    = '0;
        s       = st_q;
        sum     = '0;
        if (restart || !run) begin
            st_n   = ST_IDLE;
            bcnt_n = '0;
            wcnt_n = '0;
            werr_n = '0;
        end else if (byte_stb) begin
            if (!prbs_mode) begin
                st_n    = ST_LOCKED;
                counted = 1'b1;
                for (int i = 0; i < DATA_W; i++)
                    errs = errs + EW'(byte_in[i] ^ exp_byte[i]);
            end else begin
                counted = (st_q == ST_LOCKED);
                if (s == ST_IDLE) begin
                    s      = ST_LOAD;
                    bcnt_n = '0;
                end
                for (int i = 0; i < DATA_W; i++) begin
                    b = byte_in[DATA_W-1-i];
                    p = hist_n[TAP_A-1] ^ hist_n[LFSR_W-1];
                    unique case (s)
                        ST_LOCKED: begin
                            if (b != p) errs = errs + EW'(1);
                            hist_n = {hist_n[LFSR_W-2:0], p};
                        end
                        ST_LOAD: begin
                            hist_n = {hist_n[LFSR_W-2:0], b};
                            if (bcnt_n == BC_W'(LFSR_W - 1)) begin
                                s      = ST_VERIFY;
                                bcnt_n = '0;
                            end else begin
                                bcnt_n = bcnt_n + BC_W'(1);
                            end
                        end
                        ST_VERIFY: begin
                            hist_n = {hist_n[LFSR_W-2:0], b};
                            if (b != p) begin
                                s      = ST_LOAD;
                                bcnt_n = '0;
                            end else if (bcnt_n == BC_W'(LOCK_BITS - 1)) begin
                                s      = ST_LOCKED;
                                bcnt_n = '0;
                            end else begin
                                bcnt_n = bcnt_n + BC_W'(1);
                            end
                        end
                        default: ;
                    endcase
                end
                if (counted) begin
                    sum = werr_q + WE_W'(errs);
                    if (wcnt_q == WC_W'(WIN_FRAMES - 1)) begin
                        wcnt_n = '0;
                        werr_n = '0;
                        if (sum >= WE_W'(LOL_ERR)) begin
                            s      = ST_LOAD;
                            bcnt_n = '0;
                        end
                    end else begin
                        wcnt_n = wcnt_q + WC_W'(1);
                        werr_n = sum;
                    end
                end
                st_n = s;
            end
        end
    end

    // Output process
    always_comb begin
        locked    = (st_q == ST_LOCKED);
        frame_inc = counted;
        err_inc   = counted ? errs : '0;
    end

    // R3: in PRBS mode lock is only entered from the verify phase
    p_lock_from_verify_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCKED && $past(st_q) != ST_LOCKED && $past(prbs_mode) && !$past(restart))
        |-> $past(st_q) == ST_VERIFY);

    // R9: a stopped checker sits in IDLE
    p_idle_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q == ST_IDLE);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W  = 32,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  q
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W:0] sum;
    assign sum = {1'b0, q} + (W+1)'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (clr)    q <= '0;
        else if (sum[W]) q <= MAXV;
        else             q <= sum[W-1:0];
    end

    // R7: a full counter stays full until cleared
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q == MAXV && !clr) |=> q == MAXV);
    // R8: a clear always lands, even with an increment pending
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0);
    // R4: without a clear the count never goes down
    p_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> q >= $past(q));
endmodule

// File: rtl/tdm_slot_prbs_checker.sv
module tdm_slot_prbs_checker
    import tdm_prbs_pkg::*;
#(
    parameter int NUM_LINKS  = 60,
    parameter int LINK_W     = 6,
    parameter int SLOT_W     = 9,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 32,
    parameter int WIN_FRAMES = 4,
    parameter int LOL_ERR    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              frame_start,
    input  logic              rx_valid,
    input  logic [LINK_W-1:0] rx_link,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata
);
    localparam int EW = $clog2(DATA_W + 1);

    logic [LINK_W-1:0] sel_link_q;
    logic [SLOT_W-1:0] sel_slot_q;
    logic              en_q, mode_q, run_q;
    logic [7:0]        exp_q;
    logic              ctrl_wr, en_rise, cnt_clr;
    logic [DATA_W-1:0] capt_data;
    logic              capt_stb, locked, frame_inc;
    logic [EW-1:0]     err_inc;
    logic [EW-1:0]     inc_v [2];
    logic [CNT_W-1:0]  cnt_v [2];
    logic [31:0]       frm_ext, err_ext;
    logic              wdata_unused;

    assign wdata_unused = ^{reg_wdata[7:3], reg_wdata[9]};
    assign ctrl_wr      = reg_we && (reg_addr == A_CTRL);
    assign en_rise      = ctrl_wr && reg_wdata[0] && !en_q;
    assign cnt_clr      = soft_rst || en_rise || (ctrl_wr && reg_wdata[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_link_q <= '0;
            sel_slot_q <= '0;
            en_q       <= 1'b0;
            mode_q     <= 1'b0;
            exp_q      <= '0;
            run_q      <= 1'b0;
        end else if (soft_rst) begin
            sel_link_q <= '0;
            sel_slot_q <= '0;
            en_q       <= 1'b0;
            mode_q     <= 1'b0;
            exp_q      <= '0;
            run_q      <= 1'b0;
        end else begin
            if (reg_we && reg_addr == A_SEL) begin
                sel_link_q <= reg_wdata[15:10];
                sel_slot_q <= reg_wdata[8:0];
            end
            if (ctrl_wr) begin
                en_q   <= reg_wdata[0];
                mode_q <= reg_wdata[1];
                exp_q  <= reg_wdata[15:8];
            end
            if (en_rise)                  run_q <= 1'b1;
            else if (frame_start && !en_q) run_q <= 1'b0;
        end
    end

    tdm_slot_tap #(
        .NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)
    ) u_tap (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .sel_link(sel_link_q), .sel_slot(sel_slot_q),
        .rx_valid(rx_valid), .rx_link(rx_link), .rx_slot(rx_slot), .rx_data(rx_data),
        .capt_data(capt_data), .capt_stb(capt_stb)
    );

    prbs_lock_fsm #(
        .DATA_W(DATA_W), .WIN_FRAMES(WIN_FRAMES), .LOL_ERR(LOL_ERR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .run(run_q), .restart(en_rise), .prbs_mode(mode_q), .exp_byte(exp_q),
        .byte_stb(capt_stb), .byte_in(capt_data),
        .locked(locked), .frame_inc(frame_inc), .err_inc(err_inc)
    );

    assign inc_v[0] = EW'(frame_inc);
    assign inc_v[1] = err_inc;

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        sat_counter #(.W(CNT_W), .IW(EW)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(inc_v[g]), .q(cnt_v[g])
        );
    end

    assign frm_ext = 32'(cnt_v[0]);
    assign err_ext = 32'(cnt_v[1]);

    always_comb begin
        unique case (reg_addr)
            A_SEL:    reg_rdata = {sel_link_q, 1'b0, sel_slot_q};
            A_RXD:    reg_rdata = 16'(capt_data);
            A_CTRL:   reg_rdata = {exp_q, 5'b0, 1'b0, mode_q, en_q};
            A_FRM_LO: reg_rdata = frm_ext[15:0];
            A_FRM_HI: reg_rdata = frm_ext[31:16];
            A_ERR_LO: reg_rdata = err_ext[15:0];
            A_ERR_HI: reg_rdata = err_ext[31:16];
            A_STAT:   reg_rdata = {14'b0, run_q, locked};
            default:  reg_rdata = '0;
        endcase
    end

    // R1: the reserved select bit never reads as one
    p_sel_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_SEL) |-> reg_rdata[9] == 1'b0);
    // R9: running only ends at a frame boundary or a soft reset
    p_stop_at_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> ($past(frame_start) || $past(soft_rst)));
endmodule

// File: tb/sim_tdm_slot_prbs_checker.sv
module sim_tdm_slot_prbs_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        frame_start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [5:0]  rx_link = '0;
    logic [8:0]  rx_slot = '0;
    logic [7:0]  rx_data = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [10:0] gen = 11'h5A3;
    logic [7:0]  last_rxd = '0;

    always #10 clk = ~clk;   // 50 MHz

    tdm_slot_prbs_checker #(.CNT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame_start(frame_start),
        .rx_valid(rx_valid), .rx_link(rx_link), .rx_slot(rx_slot), .rx_data(rx_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // fields: sel_link, sel_slot, rx_link, rx_slot, data, hit
    localparam logic [38:0] VEC [8] = '{
        {6'd5,  9'd100, 6'd5,  9'd100, 8'h3C, 1'b1},
        {6'd5,  9'd100, 6'd5,  9'd101, 8'h77, 1'b0},
        {6'd5,  9'd100, 6'd4,  9'd100, 8'h66, 1'b0},
        {6'd61, 9'd7,   6'd0,  9'd7,   8'hC3, 1'b1},
        {6'd63, 9'd511, 6'd0,  9'd511, 8'h81, 1'b1},
        {6'd60, 9'd0,   6'd59, 9'd0,   8'h18, 1'b0},
        {6'd59, 9'd511, 6'd59, 9'd511, 8'hE7, 1'b1},
        {6'd0,  9'd0,   6'd0,  9'd0,   8'h42, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [5:0] l, input logic [8:0] s, input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_link = l; rx_slot = s; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic prbs_byte(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic o;
            o = gen[8] ^ gen[10];
            b[7-i] = o;
            gen = {gen[9:0], o};
        end
    endtask

    task automatic counts(input string req, input int f, input int e);
        logic [15:0] v;
        rd(3'd3, v); check(req, 32'(v), 32'(f));
        rd(3'd5, v); check(req, 32'(v), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check("R1 reset select", 32'(v), 0);
        rd(3'd2, v); check("R1 reset control", 32'(v), 0);
        rd(3'd7, v); check("R9 reset status", 32'(v), 0);
        counts("R8 reset counters", 0, 0);

        // R2 vector walk over link/slot selection
        for (int k = 0; k < 8; k++) begin
            logic [38:0] t;
            t = VEC[k];
            wr(3'd0, {t[38:33], 1'b0, t[32:24]});
            rd(3'd0, v); check("R1 select readback", 32'(v), 32'({t[38:33], 1'b0, t[32:24]}));
            send(t[23:18], t[17:9], t[8:1]);
            if (t[0]) last_rxd = t[8:1];
            rd(3'd1, v); check("R2 capture", 32'(v), 32'(last_rxd));
        end

        // PRBS mode on link 3, slot 9
        wr(3'd0, {6'd3, 1'b0, 9'd9});
        wr(3'd2, 16'h0003);
        for (int k = 0; k < 3; k++) begin prbs_byte(b); send(6'd3, 9'd9, b); end
        rd(3'd7, v); check("R3 locked after 3 bytes", 32'(v[0]), 1);
        counts("R3 nothing counted before lock", 0, 0);
        for (int k = 0; k < 3; k++) begin prbs_byte(b); send(6'd3, 9'd9, b); end
        counts("R4 clean locked frames", 3, 0);
        prbs_byte(b); send(6'd3, 9'd9, b ^ 8'h10);
        counts("R4 single bit error", 4, 1);
        for (int k = 0; k < 3; k++) begin prbs_byte(b); send(6'd3, 9'd9, b ^ 8'h81); end
        rd(3'd7, v); check("R6 lock held mid window", 32'(v[0]), 1);
        prbs_byte(b); send(6'd3, 9'd9, b ^ 8'h81);
        rd(3'd7, v); check("R6 loss of lock", 32'(v[0]), 0);
        counts("R6 counts at loss", 8, 9);
        for (int k = 0; k < 3; k++) begin prbs_byte(b); send(6'd3, 9'd9, b); end
        rd(3'd7, v); check("R6 relocked", 32'(v[0]), 1);
        counts("R6 no counting while relocking", 8, 9);

        // R9 disable waits for the frame boundary
        wr(3'd2, 16'h0002);
        rd(3'd7, v); check("R9 still running", 32'(v), 3);
        prbs_byte(b); send(6'd3, 9'd9, b);
        counts("R9 counted before boundary", 9, 9);
        pulse_frame();
        rd(3'd7, v); check("R9 stopped after boundary", 32'(v), 0);
        prbs_byte(b); send(6'd3, 9'd9, b);
        counts("R9 not counted after stop", 9, 9);

        // R5 static mode, expected 0xA5
        wr(3'd2, 16'hA501);
        counts("R8 cleared by enable", 0, 0);
        send(6'd3, 9'd9, 8'hA5);
        counts("R5 static match", 1, 0);
        send(6'd3, 9'd9, 8'h5A);
        counts("R5 static all bits wrong", 2, 8);
        send(6'd3, 9'd9, 8'h5A);
        counts("R7 error saturation", 3, 15);
        for (int k = 0; k < 13; k++) send(6'd3, 9'd9, 8'hA5);
        counts("R7 frame saturation", 15, 15);

        // R8 clear in the same cycle as an increment
        @(negedge clk);
        rx_valid = 1'b1; rx_link = 6'd3; rx_slot = 9'd9; rx_data = 8'h00;
        @(negedge clk);
        rx_valid = 1'b0;
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 16'hA505;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
        counts("R8 clear beats increment", 0, 0);
        send(6'd3, 9'd9, 8'hA4);
        counts("R5 one bit off", 1, 1);

        // R1 soft reset
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); check("R1 reserved bit reads zero", 32'(v), 32'h0000FDFF);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        rd(3'd0, v); check("R1 soft reset select", 32'(v), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule